// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block watches the clock and data lines of a two-wire serial bus and decides whether the local device is the target of the current transfer. It handles short (7-bit) addressing, long (10-bit) addressing with its write-then-read turnaround, and the all-zero broadcast address with its command byte. Both lines pass through a two-flop synchroniser, and start, repeated-start and stop are detected on the synchronised samples.

The own short address is a fixed device-type field in its upper bits and a few board-strapped pin bits in its lower bits. The long address is a fixed upper field plus the same pin bits. The block pulls SDA low in the acknowledge slot and reports selection, transfer direction, one-cycle reset and reload strobes from the broadcast command, and a broadcast-data mode flag. The byte data path that follows selection is left to a neighbouring block.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset all outputs are low and SDA is released.
- R2: A first byte after start or repeated start whose bits 7:1 equal {DEV_TYPE, addr_pins_i} is acknowledged. selected_o is then set and read_o takes bit 0, where 1 means read.
- R3: A first byte that matches no accepted address is not acknowledged. Every later byte of that transfer is also left unacknowledged, even 0x00 or the own address, until the next start.
- R4: While selected for write, every following byte is acknowledged. While selected for read, SDA stays released in the acknowledge slots.
- R5: A long-address write is a header 11110 h h 0, where h h equal own address bits 9:8, followed by a byte equal to own bits 7:0. Both bytes are acknowledged and the block becomes selected for write. A wrong header or a wrong low byte is not acknowledged.
- R6: A header 11110 h h 1 is acknowledged, with selected_o and read_o set, only if a full long-address match has been made before it. That memory survives repeated starts, and is cleared by a stop or by any other first byte.
- R7: A first byte 0x00 is acknowledged. A second byte 0x06 is acknowledged and gives a one-cycle pulse on both gc_reset_o and gc_reload_o. A second byte 0x04 is acknowledged and pulses gc_reload_o alone.
- R8: Any other broadcast second byte with bit 0 = 0 is not acknowledged and gives no pulse.
- R9: A broadcast second byte with bit 0 = 1 is acknowledged and sets bcast_o. Every later byte of the transfer is then acknowledged.
- R10: A stop clears selected_o, read_o and bcast_o.
- R11: A repeated start clears selected_o, read_o and bcast_o, and the next byte is decoded as a first byte.
- R12: The acknowledge pull-down starts at the SCL fall after the eighth bit and ends at the SCL fall that closes the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pins_i | input | PIN_W | Strapped low address bits |
| sda_drive_o | output | 1 | 1 = pull SDA low (acknowledge) |
| selected_o | output | 1 | Device addressed in this transfer |
| read_o | output | 1 | Selected for read (device transmits) |
| gc_reset_o | output | 1 | One-cycle reset request from the broadcast command |
| gc_reload_o | output | 1 | One-cycle address-reload request |
| bcast_o | output | 1 | Broadcast data bytes follow |

## Verification
A wrong decode state shows at the next acknowledge slot: the bus reads a missing or extra acknowledge about four clocks after SCL falls following the eighth bit. selected_o, read_o and bcast_o settle on that same edge. A stale long-address memory is seen only at the next read header, so the sequences put stops and other first bytes between a long write and the read that follows. A broken start or stop detector shows up when the first byte is framed wrongly, or when selection survives a stop or a repeated start.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_TEN2, ST_GC2, ST_DATA
  } am_state_e;

  localparam int unsigned BYTE_W     = 8;
  localparam logic [4:0]  TEN_PREFIX = 5'b11110;
  localparam logic [7:0]  GC_ADDR    = 8'h00;
  localparam logic [7:0]  GC_RESET   = 8'h06;
  localparam logic [7:0]  GC_RELOAD  = 8'h04;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ff_q <= '1;   // idle bus is high
    else         ff_q <= {ff_q[STAGES-2:0], d_i};

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift
  import i2c_am_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o,
  output logic              ack_end_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              in_ack_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      in_ack_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
    end else if (rise_i && cnt_q < FULL) begin
      sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
      cnt_q <= cnt_q + 1'b1;
    end else if (fall_i && cnt_q == FULL) begin
      if (in_ack_q) begin
        in_ack_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        in_ack_q <= 1'b1;
      end
    end

  assign byte_o    = sh_q;
  assign done_o    = fall_i && cnt_q == FULL && !in_ack_q;
  assign ack_end_o = fall_i && cnt_q == FULL && in_ack_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       TYPE_W      = 4,
  parameter int unsigned       PIN_W       = 3,
  parameter logic [TYPE_W-1:0] DEV_TYPE    = 4'b1010,
  parameter logic [9-PIN_W:0]  TEN_FIXED   = 7'b1011001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] addr_pins_i,
  output logic             sda_drive_o,
  output logic             selected_o,
  output logic             read_o,
  output logic             gc_reset_o,
  output logic             gc_reload_o,
  output logic             bcast_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw, syn;
  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < N_LINES; i++) begin : g_sync
    i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw[i]), .q_o(syn[i])
    );
  end

  logic start, stop, rise, fall;
  i2c_am_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(syn[0]), .sda_i(syn[1]),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  logic [BYTE_W-1:0] b;
  logic done, ack_end;
  i2c_am_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start | stop),
    .rise_i(rise), .fall_i(fall), .sda_i(syn[1]),
    .byte_o(b), .done_o(done), .ack_end_o(ack_end)
  );

  logic [6:0] own7;
  logic [9:0] own10;
  assign own7  = {DEV_TYPE, addr_pins_i};
  assign own10 = {TEN_FIXED, addr_pins_i};

  am_state_e state_q;
  logic sel_q, rd_q, bc_q, ten_q, drv_q, rst_p_q, rel_p_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      {sel_q, rd_q, bc_q, ten_q, drv_q, rst_p_q, rel_p_q} <= '0;
    end else begin
      rst_p_q <= 1'b0;
      rel_p_q <= 1'b0;
      if (stop) begin
        state_q <= ST_IDLE;
        {sel_q, rd_q, bc_q, ten_q, drv_q} <= '0;
      end else if (start) begin            // start or repeated start
        state_q <= ST_ADDR;
        {sel_q, rd_q, bc_q, drv_q} <= '0;
      end else if (ack_end) begin
        drv_q <= 1'b0;
      end else if (done) begin
        unique case (state_q)
          ST_ADDR: begin
            ten_q   <= 1'b0;
            state_q <= ST_IDLE;
            if (b[7:1] == own7) begin
              {drv_q, sel_q} <= 2'b11;
              rd_q    <= b[0];
              state_q <= ST_DATA;
            end else if (b == GC_ADDR) begin
              drv_q   <= 1'b1;
              state_q <= ST_GC2;
            end else if (b[7:3] == TEN_PREFIX && b[2:1] == own10[9:8]) begin
              if (!b[0]) begin
                drv_q   <= 1'b1;
                state_q <= ST_TEN2;
              end else if (ten_q) begin  // read turnaround after full match
                {drv_q, sel_q, rd_q, ten_q} <= '1;
                state_q <= ST_DATA;
              end
            end
          end
          ST_TEN2: begin
            state_q <= ST_IDLE;
            if (b == own10[7:0]) begin
              {drv_q, sel_q, ten_q} <= '1;
              rd_q    <= 1'b0;
              state_q <= ST_DATA;
            end
          end
          ST_GC2: begin
            state_q <= ST_IDLE;
            if (b == GC_RESET) begin
              {drv_q, rst_p_q, rel_p_q} <= '1;
            end else if (b == GC_RELOAD) begin
              {drv_q, rel_p_q} <= '1;
            end else if (b[0]) begin
              {drv_q, bc_q} <= '1;
              state_q <= ST_DATA;
            end
          end
          ST_DATA: drv_q <= ~rd_q;
          default: ;
        endcase
      end
    end

  assign sda_drive_o = drv_q;
  assign selected_o  = sel_q;
  assign read_o      = rd_q;
  assign gc_reset_o  = rst_p_q;
  assign gc_reload_o = rel_p_q;
  assign bcast_o     = bc_q;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_drive_o,
  input logic selected_o,
  input logic read_o,
  input logic gc_reset_o,
  input logic gc_reload_o,
  input logic bcast_o
);
  // R7
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reset_o |=> !gc_reset_o);
  // R7
  rst_with_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reset_o |-> gc_reload_o);
  // R7
  reload_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reload_o |-> sda_drive_o);
  // R2
  read_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_o |-> selected_o);
  // R12
  sel_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(selected_o) |-> sda_drive_o);
  // R9
  bcast_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcast_o) |-> sda_drive_o);
  // R9
  sel_bcast_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(selected_o && bcast_o));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (.*);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;   // quarter bit in clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic drv, sel, rd, gcr, gcl, bc;
  logic sda_line;
  int checks = 0, errors = 0;
  int n_rst = 0, n_rel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~drv;

  i2c_addr_match u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins_i(pins), .sda_drive_o(drv), .selected_o(sel), .read_o(rd),
    .gc_reset_o(gcr), .gc_reload_o(gcl), .bcast_o(bc)
  );

  always_ff @(posedge clk) begin
    if (gcr) n_rst <= n_rst + 1;
    if (gcl) n_rel <= n_rel + 1;
  end

  // own short addr 1010101: write AA, read AB; own long addr hi=10 low=CD
  // fields: first, has_second, second, ack1, ack2, sel, rd, bc, rst, rel
  localparam logic [23:0] VEC [0:10] = '{
    {8'hAA, 1'b0, 8'h00, 7'b1010000},  // R2 write
    {8'hAB, 1'b0, 8'h00, 7'b1011000},  // R2 read
    {8'hA8, 1'b0, 8'h00, 7'b0000000},  // R3 other device
    {8'h00, 1'b1, 8'h06, 7'b1100011},  // R7 reset+reload
    {8'h00, 1'b1, 8'h04, 7'b1100001},  // R7 reload
    {8'h00, 1'b1, 8'h02, 7'b1000000},  // R8 ignored
    {8'h00, 1'b1, 8'hA5, 7'b1100100},  // R9 broadcast
    {8'hF4, 1'b1, 8'hCD, 7'b1110000},  // R5 long write
    {8'hF4, 1'b1, 8'hCE, 7'b1000000},  // R5 wrong low byte
    {8'hF6, 1'b1, 8'hCD, 7'b0000000},  // R5 wrong header
    {8'hF5, 1'b0, 8'h00, 7'b0000000}   // R6 read header after stop
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:    return "R2";
      2:       return "R3";
      3, 4:    return "R7";
      5:       return "R8";
      6:       return "R9";
      7, 8, 9: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  logic a1, a2;
  int r0, l0;

  initial begin
    wq(3);
    // R1 reset state
    chk("R1 sel", sel, 0); chk("R1 rd", rd, 0); chk("R1 bc", bc, 0);
    chk("R1 drv", drv, 0); chk("R1 gcr", gcr, 0); chk("R1 gcl", gcl, 0);
    rst_n = 1'b1; wq(4);
    chk("R1 drv after release", drv, 0);

    for (int i = 0; i < 11; i++) begin
      logic [23:0] v;
      v = VEC[i];
      r0 = n_rst; l0 = n_rel; a2 = 1'b0;
      do_start();
      send(v[23:16], a1);
      if (v[15]) send(v[14:7], a2);
      chk({vtag(i), " ack1"}, a1, v[6]);
      if (v[15]) chk({vtag(i), " ack2"}, a2, v[5]);
      chk({vtag(i), " sel"}, sel, v[4]);
      chk({vtag(i), " rd"}, rd, v[3]);
      chk({vtag(i), " bc"}, bc, v[2]);
      chk({vtag(i), " reset pulses"}, n_rst - r0, v[1]);
      chk({vtag(i), " reload pulses"}, n_rel - l0, v[0]);
      do_stop();
      chk("R10 sel cleared", sel, 0);
      chk("R10 bc cleared", bc, 0);
      chk("R10 rd cleared", rd, 0);
    end

    // R4 R12 write data acked, drive released after ninth clock
    do_start(); send(8'hAA, a1);
    chk("R12 release after ack", drv, 0);
    send(8'h3C, a1); chk("R4 data ack", a1, 1);
    send(8'h00, a1); chk("R4 zero data ack", a1, 1);
    chk("R4 still selected", sel, 1);
    do_stop();

    // R4 read: no ack drive on data slots
    do_start(); send(8'hAB, a1); chk("R2 read ack", a1, 1);
    send(8'hFF, a1); chk("R4 read slot released", a1, 0);
    do_stop();

    // R6 R11 long read turnaround
    do_start(); send(8'hF4, a1); send(8'hCD, a2);
    chk("R5 long write sel", sel, 1);
    do_start();
    chk("R11 sel cleared by restart", sel, 0);
    send(8'hF5, a1);
    chk("R6 read header ack", a1, 1); chk("R6 sel", sel, 1); chk("R6 rd", rd, 1);
    do_start(); send(8'hF5, a1);
    chk("R6 memory kept over restart", a1, 1);
    do_stop();

    // R6 memory cleared by another first byte
    do_start(); send(8'hF4, a1); send(8'hCD, a2);
    do_start(); send(8'hA8, a1); chk("R3 other nack", a1, 0);
    do_start(); send(8'hF5, a1);
    chk("R6 memory cleared", a1, 0); chk("R6 not selected", sel, 0);
    do_stop();

    // R9 R11 broadcast data, cleared by restart
    do_start(); send(8'h00, a1); send(8'hA5, a2);
    send(8'h11, a1); chk("R9 bcast data ack", a1, 1); chk("R9 bc", bc, 1);
    do_start(); chk("R11 bc cleared", bc, 0);
    send(8'hA8, a1); chk("R11 new first byte decoded", a1, 0);
    do_stop();

    // R3 later bytes ignored after mismatch
    do_start(); send(8'hA8, a1);
    send(8'h00, a1); chk("R3 zero ignored", a1, 0);
    send(8'hAA, a2); chk("R3 own ignored", a2, 0);
    chk("R3 not selected", sel, 0);
    do_stop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule